// File: doc/BRIEF.md
# Cache-Side Directory Coherence Controller

This block keeps a small direct-mapped cache coherent with a home directory. Each line is Invalid, Shared (read-only) or Exclusive (read/write). It accepts CPU reads and writes and completes them. When a line is missing, or is held read-only and written, it sends an explicit message to the home directory and does not broadcast. The directory in turn sends commands that invalidate, fetch or fetch-and-invalidate a line, and it answers each miss with a data reply.

The CPU side uses a ready/request handshake. A hit finishes one cycle after it is accepted. A miss holds the CPU port stalled until a reply for the pending address arrives, and the new line state is committed in the cycle of that reply. One word is kept per line. The line index is the low address bits and the tag is the rest. A directory message in a cycle takes precedence over a new CPU request.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset cpu_ready is 1, msg_valid and cpu_done are 0 and every line is Invalid, so the first access to any address sends a miss. msg_type never carries code 3.
- R2: A CPU read (cpu_we=0) of an Invalid line sends a read miss (msg_type 0) with the address in the cycle after acceptance. cpu_ready stays 0 until a reply (dir_type 3) with the same address arrives. In the next cycle cpu_done pulses with the reply data, and the line becomes Shared.
- R3: A CPU write of an Invalid line sends a write miss (msg_type 1). On the reply the line becomes Exclusive with the CPU write data, and cpu_rdata returns that write data.
- R4: A CPU write to a Shared line with a matching tag sends a write miss and, on the reply, the line becomes Exclusive.
- R5: A read hit in Shared or Exclusive, and a write hit in Exclusive, complete with cpu_done one cycle after acceptance and send no message. A write hit updates the stored word.
- R6: An invalidate (dir_type 0) to a Shared line makes it Invalid. It sends no message.
- R7: A fetch (dir_type 1) to an Exclusive line sends a data write-back (msg_type 2) with the line address and data in the next cycle, and the line becomes Shared.
- R8: A fetch/invalidate (dir_type 2) to an Exclusive line sends a data write-back and the line becomes Invalid.
- R9: A miss whose line index holds an Exclusive line of another tag first sends a write-back of the old address and data in the cycle after acceptance. It then sends the new read or write miss.
- R10: A miss whose line index holds a Shared line of another tag sends only the new miss.
- R11: A reply whose address differs from the pending miss is ignored. The CPU port stays stalled and no completion is given.
- R12: cpu_ready is 0 in any cycle in which dir_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_ready | output | 1 | Request accepted when high together with cpu_req |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line word after the completed access |
| dir_valid | input | 1 | Directory message present |
| dir_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch/invalidate, 3 data reply |
| dir_addr | input | ADDR_W | Address of directory message |
| dir_data | input | DATA_W | Reply data |
| msg_valid | output | 1 | Outgoing message present (one cycle) |
| msg_type | output | 2 | 0 read miss, 1 write miss, 2 data write-back |
| msg_addr | output | ADDR_W | Outgoing message address |
| msg_data | output | DATA_W | Write-back data (0 for misses) |

## Verification
Hit completions, the first outgoing message of a miss, and write-backs caused by a fetch all appear one cycle after the edge that takes in the request or command. The second message of a replacement follows one cycle later, and a miss completion follows one cycle after its reply. The bench drives on falling edges and queues every expected message and completion in order. A monitor samples at each falling edge, so each registered result is compared in the half-cycle after it appears, and a result that arrives early, late or unannounced is reported. Stall behaviour is checked by reading cpu_ready during an ignored reply and during directory traffic.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHD = 2'd1, LS_EXC = 2'd2} lstate_t;
  typedef enum logic [1:0] {DM_INV = 2'd0, DM_FETCH = 2'd1, DM_FETCH_INV = 2'd2, DM_REPLY = 2'd3} dmsg_t;
  typedef enum logic [1:0] {OM_RDMISS = 2'd0, OM_WRMISS = 2'd1, OM_WB = 2'd2} omsg_t;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_SEND = 2'd1, F_WAIT = 2'd2} fsm_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  c_idx,
  output lstate_t           c_state,
  output logic [TAG_W-1:0]  c_tag,
  output logic [DATA_W-1:0] c_data,
  input  logic [IDX_W-1:0]  d_idx,
  output lstate_t           d_state,
  output logic [TAG_W-1:0]  d_tag,
  output logic [DATA_W-1:0] d_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  lstate_t           wr_state,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  lstate_t           st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        st_q[i]   <= LS_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        st_q[i]   <= wr_state;
        tag_q[i]  <= wr_tag;
        data_q[i] <= wr_data;
      end
    end
  end

  assign c_state = st_q[c_idx];
  assign c_tag   = tag_q[c_idx];
  assign c_data  = data_q[c_idx];
  assign d_state = st_q[d_idx];
  assign d_tag   = tag_q[d_idx];
  assign d_data  = data_q[d_idx];
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dir_valid,
  input  logic [1:0]        dir_type,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DATA_W-1:0] dir_data,
  output logic              msg_valid,
  output logic [1:0]        msg_type,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic [IDX_W-1:0]  c_idx,
  input  lstate_t           c_state,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic [DATA_W-1:0] c_data,
  output logic [IDX_W-1:0]  d_idx,
  input  lstate_t           d_state,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [DATA_W-1:0] d_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output lstate_t           wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              ev_hit,
  output logic              ev_wb_first,
  output logic              ev_reply,
  output logic              ev_snoop_wb
);
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  fsm_t              fsm_q;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_we;
  logic [DATA_W-1:0] pend_wdata;

  logic accept, c_match, miss_go, need_wb, d_match, snoop_inv, send_step;

  assign c_idx     = idx_of(cpu_addr);
  assign d_idx     = idx_of(dir_addr);
  assign cpu_ready = (fsm_q == F_IDLE) && !dir_valid;
  assign accept    = cpu_ready && cpu_req;
  assign c_match   = (c_state != LS_INV) && (c_tag == tag_of(cpu_addr));
  assign ev_hit    = accept && c_match && (!cpu_we || c_state == LS_EXC);
  assign miss_go   = accept && !ev_hit;
  assign need_wb   = miss_go && (c_state == LS_EXC) && (c_tag != tag_of(cpu_addr));
  assign ev_wb_first = need_wb;
  assign d_match   = (d_state != LS_INV) && (d_tag == tag_of(dir_addr));
  assign snoop_inv = dir_valid && (dir_type == DM_INV) && d_match && (d_state == LS_SHD);
  assign ev_snoop_wb = dir_valid && (dir_type == DM_FETCH || dir_type == DM_FETCH_INV)
                       && d_match && (d_state == LS_EXC);
  assign ev_reply  = (fsm_q == F_WAIT) && dir_valid && (dir_type == DM_REPLY)
                     && (dir_addr == pend_addr);
  assign send_step = (fsm_q == F_SEND) && !dir_valid;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = d_idx;
    wr_state = d_state;
    wr_tag   = d_tag;
    wr_data  = d_data;
    if (snoop_inv) begin
      wr_en    = 1'b1;
      wr_state = LS_INV;
    end else if (ev_snoop_wb) begin
      wr_en    = 1'b1;
      wr_state = (dir_type == DM_FETCH) ? LS_SHD : LS_INV;
    end else if (ev_reply) begin
      wr_en    = 1'b1;
      wr_idx   = idx_of(pend_addr);
      wr_state = pend_we ? LS_EXC : LS_SHD;
      wr_tag   = tag_of(pend_addr);
      wr_data  = pend_we ? pend_wdata : dir_data;
    end else if (ev_hit && cpu_we) begin
      wr_en    = 1'b1;
      wr_idx   = c_idx;
      wr_state = LS_EXC;
      wr_tag   = c_tag;
      wr_data  = cpu_wdata;
    end else if (need_wb) begin
      wr_en    = 1'b1;
      wr_idx   = c_idx;
      wr_state = LS_INV;
      wr_tag   = c_tag;
      wr_data  = c_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= F_IDLE;
      pend_addr  <= '0;
      pend_we    <= 1'b0;
      pend_wdata <= '0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      msg_valid  <= 1'b0;
      msg_type   <= OM_RDMISS;
      msg_addr   <= '0;
      msg_data   <= '0;
    end else begin
      cpu_done  <= ev_hit || ev_reply;
      if (ev_hit)
        cpu_rdata <= cpu_we ? cpu_wdata : c_data;
      else if (ev_reply)
        cpu_rdata <= pend_we ? pend_wdata : dir_data;

      msg_valid <= 1'b0;
      if (ev_snoop_wb) begin
        msg_valid <= 1'b1;
        msg_type  <= OM_WB;
        msg_addr  <= dir_addr;
        msg_data  <= d_data;
      end else if (need_wb) begin
        msg_valid <= 1'b1;
        msg_type  <= OM_WB;
        msg_addr  <= {c_tag, c_idx};
        msg_data  <= c_data;
      end else if (miss_go) begin
        msg_valid <= 1'b1;
        msg_type  <= cpu_we ? OM_WRMISS : OM_RDMISS;
        msg_addr  <= cpu_addr;
        msg_data  <= '0;
      end else if (send_step) begin
        msg_valid <= 1'b1;
        msg_type  <= pend_we ? OM_WRMISS : OM_RDMISS;
        msg_addr  <= pend_addr;
        msg_data  <= '0;
      end

      if (miss_go) begin
        pend_addr  <= cpu_addr;
        pend_we    <= cpu_we;
        pend_wdata <= cpu_wdata;
      end

      case (fsm_q)
        F_IDLE:  if (need_wb) fsm_q <= F_SEND; else if (miss_go) fsm_q <= F_WAIT;
        F_SEND:  if (send_step) fsm_q <= F_WAIT;
        F_WAIT:  if (ev_reply) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dir_valid,
  input  logic [1:0]        dir_type,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DATA_W-1:0] dir_data,
  output logic              msg_valid,
  output logic [1:0]        msg_type,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, d_idx, wr_idx;
  lstate_t           c_state, d_state, wr_state;
  logic [TAG_W-1:0]  c_tag, d_tag, wr_tag;
  logic [DATA_W-1:0] c_data, d_data, wr_data;
  logic              wr_en;
  logic              ev_hit, ev_wb_first, ev_reply, ev_snoop_wb;

  coh_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .c_idx(c_idx), .c_state(c_state), .c_tag(c_tag), .c_data(c_data),
    .d_idx(d_idx), .d_state(d_state), .d_tag(d_tag), .d_data(d_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  coh_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .dir_valid(dir_valid), .dir_type(dir_type), .dir_addr(dir_addr), .dir_data(dir_data),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_addr(msg_addr), .msg_data(msg_data),
    .c_idx(c_idx), .c_state(c_state), .c_tag(c_tag), .c_data(c_data),
    .d_idx(d_idx), .d_state(d_state), .d_tag(d_tag), .d_data(d_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_tag(wr_tag), .wr_data(wr_data),
    .ev_hit(ev_hit), .ev_wb_first(ev_wb_first), .ev_reply(ev_reply), .ev_snoop_wb(ev_snoop_wb)
  );
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_valid,
  input logic [ADDR_W-1:0] dir_addr,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              msg_valid,
  input logic [1:0]        msg_type,
  input logic [ADDR_W-1:0] msg_addr,
  input logic              ev_hit,
  input logic              ev_wb_first,
  input logic              ev_reply,
  input logic              ev_snoop_wb
);
  // R5
  hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (cpu_done && !msg_valid));
  // R9
  wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_first |=> (msg_valid && msg_type == 2'd2));
  // R7
  snoop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snoop_wb |=> (msg_valid && msg_type == 2'd2 && msg_addr == $past(dir_addr)));
  // R12
  dir_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid |-> !cpu_ready);
  // R2
  reply_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reply |=> cpu_done);
  // R1
  msg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_type != 2'd3));
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_valid(dir_valid), .dir_addr(dir_addr),
  .cpu_ready(cpu_ready), .cpu_done(cpu_done), .msg_valid(msg_valid),
  .msg_type(msg_type), .msg_addr(msg_addr), .ev_hit(ev_hit),
  .ev_wb_first(ev_wb_first), .ev_reply(ev_reply), .ev_snoop_wb(ev_snoop_wb)
);

// File: tb/tb_coh_line_ctrl.sv
`timescale 1ns/1ps
module tb_coh_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [15:0] cpu_rdata;
  logic        dir_valid = 1'b0;
  logic [1:0]  dir_type = '0;
  logic [7:0]  dir_addr = '0;
  logic [15:0] dir_data = '0;
  logic        msg_valid;
  logic [1:0]  msg_type;
  logic [7:0]  msg_addr;
  logic [15:0] msg_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    bit          is_msg;
    logic [1:0]  mtype;
    logic [7:0]  addr;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  coh_line_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .dir_valid(dir_valid), .dir_type(dir_type), .dir_addr(dir_addr), .dir_data(dir_data),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_msg(input logic [1:0] t, input logic [7:0] a, input logic [15:0] d,
                          input string req);
    exp_t e;
    e.is_msg = 1'b1; e.mtype = t; e.addr = a; e.data = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic push_done(input logic [15:0] d, input string req);
    exp_t e;
    e.is_msg = 1'b0; e.mtype = 2'd0; e.addr = 8'd0; e.data = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic observe(input bit is_msg);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R5", is_msg ? "unexpected message" : "unexpected completion",
            is_msg ? {22'd0, msg_type, msg_addr} : {16'd0, cpu_rdata}, 32'd0);
      return;
    end
    e = q.pop_front();
    if (is_msg)
      check(e.is_msg && msg_type == e.mtype && msg_addr == e.addr &&
            (msg_type != 2'd2 || msg_data == e.data), e.req, "message {type,addr,data}",
            {6'd0, msg_type, msg_addr, msg_data}, {6'd0, e.mtype, e.addr, e.data});
    else
      check(!e.is_msg && cpu_rdata == e.data, e.req, "completion data",
            {15'd0, e.is_msg, cpu_rdata}, {16'd0, e.data});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (msg_valid) observe(1'b1);
      if (cpu_done)  observe(1'b0);
    end
  end

  task automatic cpu_access(input bit we, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic dir_send(input logic [1:0] t, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    dir_valid = 1'b1; dir_type = t; dir_addr = a; dir_data = d;
    #1;
    check(cpu_ready == 1'b0, "R12", "cpu_ready under directory traffic", {31'd0, cpu_ready}, 32'd0);
    @(negedge clk);
    dir_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    check(cpu_ready == 1'b1, "R1", "cpu_ready after reset", {31'd0, cpu_ready}, 32'd1);
    check(msg_valid == 1'b0, "R1", "msg_valid after reset", {31'd0, msg_valid}, 32'd0);
    check(cpu_done == 1'b0, "R1", "cpu_done after reset", {31'd0, cpu_done}, 32'd0);

    // R2: read from Invalid, then reply
    push_msg(2'd0, 8'h10, 16'h0, "R2");
    cpu_access(1'b0, 8'h10, 16'h0);
    idle(2);
    check(cpu_ready == 1'b0, "R2", "stall while miss pending", {31'd0, cpu_ready}, 32'd0);
    push_done(16'hA1A1, "R2");
    dir_send(2'd3, 8'h10, 16'hA1A1);
    idle(2);
    // R5: read hit in Shared
    push_done(16'hA1A1, "R5");
    cpu_access(1'b0, 8'h10, 16'h0);
    idle(2);
    // R4: write on Shared upgrades
    push_msg(2'd1, 8'h10, 16'h0, "R4");
    cpu_access(1'b1, 8'h10, 16'hB2B2);
    push_done(16'hB2B2, "R4");
    dir_send(2'd3, 8'h10, 16'hFFFF);
    idle(2);
    // R5: hits in Exclusive
    push_done(16'hB2B2, "R5");
    cpu_access(1'b0, 8'h10, 16'h0);
    push_done(16'hC3C3, "R5");
    cpu_access(1'b1, 8'h10, 16'hC3C3);
    idle(2);
    // R7: fetch writes back, line Shared
    push_msg(2'd2, 8'h10, 16'hC3C3, "R7");
    dir_send(2'd1, 8'h10, 16'h0);
    idle(2);
    push_done(16'hC3C3, "R7");
    cpu_access(1'b0, 8'h10, 16'h0);
    push_msg(2'd1, 8'h10, 16'h0, "R7");
    cpu_access(1'b1, 8'h10, 16'hD4D4);
    push_done(16'hD4D4, "R7");
    dir_send(2'd3, 8'h10, 16'h0);
    idle(2);
    // R8: fetch/invalidate writes back, line Invalid
    push_msg(2'd2, 8'h10, 16'hD4D4, "R8");
    dir_send(2'd2, 8'h10, 16'h0);
    idle(2);
    push_msg(2'd0, 8'h10, 16'h0, "R8");
    cpu_access(1'b0, 8'h10, 16'h0);
    push_done(16'hE5E5, "R8");
    dir_send(2'd3, 8'h10, 16'hE5E5);
    idle(2);
    // R6: invalidate a Shared line, no message
    dir_send(2'd0, 8'h10, 16'h0);
    idle(2);
    push_msg(2'd0, 8'h10, 16'h0, "R6");
    cpu_access(1'b0, 8'h10, 16'h0);
    push_done(16'hF6F6, "R6");
    dir_send(2'd3, 8'h10, 16'hF6F6);
    idle(2);
    // R3: write from Invalid
    push_msg(2'd1, 8'h21, 16'h0, "R3");
    cpu_access(1'b1, 8'h21, 16'h1234);
    push_done(16'h1234, "R3");
    dir_send(2'd3, 8'h21, 16'h9999);
    idle(2);
    push_done(16'h1234, "R3");
    cpu_access(1'b0, 8'h21, 16'h0);
    idle(2);
    // R9: replace Exclusive line of another tag
    push_msg(2'd2, 8'h21, 16'h1234, "R9");
    push_msg(2'd0, 8'h25, 16'h0, "R9");
    cpu_access(1'b0, 8'h25, 16'h0);
    idle(2);
    push_done(16'h5555, "R9");
    dir_send(2'd3, 8'h25, 16'h5555);
    idle(2);
    // R10: replace Shared line, miss only; R11: wrong reply ignored
    push_msg(2'd0, 8'h29, 16'h0, "R10");
    cpu_access(1'b0, 8'h29, 16'h0);
    idle(1);
    dir_send(2'd3, 8'h25, 16'h7777);
    idle(2);
    check(cpu_ready == 1'b0, "R11", "stall after mismatched reply", {31'd0, cpu_ready}, 32'd0);
    push_done(16'h6666, "R10");
    dir_send(2'd3, 8'h29, 16'h6666);
    idle(3);
    check(q.size() == 0, "R11", "outstanding expected items", q.size(), 32'd0);
    finish_run();
  end
endmodule